// File: doc/BRIEF.md
# Bit Field Operation Unit

This unit carries out one operation on a bit field of up to 32 bits that sits somewhere in byte-addressed memory. A request gives a base byte address, a signed bit offset counted from the most significant bit of that byte, and a field length. The unit turns these into a byte address and a bit position. It then picks the smallest power-of-two load (1, 2, 4 or 8 bytes) that covers the field, moving the address down where a long or quad load needs it. The address and the load size are driven combinationally, so the memory side can return the loaded bytes in the same cycle.

The loaded bytes come back right-justified in a 64-bit big-endian window. The unit then extracts (signed or unsigned), inserts, inverts, clears or sets the field, or finds its first one bit. One cycle later it presents the registered result, a left-justified value for the negative flag, and, for the modifying operations, the window to write back together with its address and size. The memory access itself belongs to the surrounding logic.

Top module: `bitfield_unit`

## Requirements
- R1: The effective field length is `in_len` when `in_len` is non-zero. A value of 0 on `in_len` means 32.
- R2: The field starts at absolute bit `8*in_base + in_ofs`, where bit 0 is the MSB of the byte at `in_base` and `in_ofs` is two's complement. The unit splits this into a floor byte address and a bit position from 0 to 7.
- R3: With span = (bit position + length - 1) / 8, `ld_size` is 0 (byte) for span 0, 1 (word) for span 1, 2 (long) for spans 2 and 3, and 3 (quad) for span 4. The loaded bytes occupy the low bytes of `win_in`, with the lowest address most significant, and they always contain the whole field.
- R4: For span 2 at an odd byte address, `ld_addr` is the byte address minus one. A long access with span 2 therefore never uses an odd address.
- R5: For span 4, `ld_addr` is the byte address rounded down to a multiple of 4.
- R6: Code 0 returns the field zero-extended and code 1 returns it sign-extended. Both give the field left-justified as the flag value and request no store.
- R7: Codes 3, 2... are as follows: code 3 inverts the field, code 4 clears it and code 5 sets it in the store window. All other window bits stay unchanged. The result is the original field zero-extended, and the flag value is the original field left-justified.
- R8: Code 2 replaces the field with the low `length` bits of `in_ins`. The result is those bits zero-extended, and the flag value is `in_ins` shifted left by (32 - length).
- R9: Code 6 returns `in_ofs` plus the number of zero bits before the first one bit of the field. If the field is all zero, it returns `in_ofs` plus the length. The flag value is the field left-justified, and no store is requested.
- R10: `out_valid` follows `in_valid` by exactly one clock. `st_en` is high only with `out_valid`, and only for codes 2 to 5. Code 7 yields result 0 and flag 0 and requests no store.
- R11: While `rst` is high at a clock edge, `out_valid`, `st_en`, `out_result` and `out_flag` become 0.
- R12: `st_addr` and `st_size` present the load address and size of the request that produced the current output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 3 | Operation code |
| in_base | input | ADDR_W | Base byte address |
| in_ofs | input | OFS_W | Signed bit offset |
| in_len | input | 5 | Field length, 0 means 32 |
| in_ins | input | 32 | Value to insert |
| win_in | input | 64 | Loaded bytes, right-justified |
| ld_addr | output | ADDR_W | Load address (combinational) |
| ld_size | output | 2 | Load size code (combinational) |
| out_valid | output | 1 | Registered outputs valid |
| out_result | output | 32 | Operation result |
| out_flag | output | 32 | Left-justified value for the negative flag |
| st_en | output | 1 | Write-back requested |
| st_win | output | 64 | Window to write back |
| st_addr | output | ADDR_W | Write-back address |
| st_size | output | 2 | Write-back size code |

## Verification
Two pieces of address logic can act on the same request. One is the floor normalisation of a negative offset. The other is the realignment of a long or quad access. The bench provokes both at once with negative offsets whose floor byte address is odd and whose span needs a long or a quad load. It judges the result with a bit-level memory model that is independent of the unit's window arithmetic. The model checks the address and size against hand-derived values, confirms that every field bit lies inside the fetched bytes, and confirms that exactly those bits change in the write-back window.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    localparam int BF_WIN_W = 64;
    localparam int BF_FLD_W = 32;

    typedef enum logic [2:0] {
        BF_EXTU = 3'd0,
        BF_EXTS = 3'd1,
        BF_INS  = 3'd2,
        BF_CHG  = 3'd3,
        BF_CLR  = 3'd4,
        BF_SET  = 3'd5,
        BF_FFO  = 3'd6,
        BF_NOP  = 3'd7
    } bf_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_QUAD = 2'd3
    } bf_size_e;

    typedef struct packed {
        logic [5:0] wpos;   // bit position of field MSB in 64-bit window, from the top
        logic [5:0] len;    // effective length 1..32
        bf_size_e   size;
    } bf_loc_t;

    function automatic logic [5:0] bf_eff_len(input logic [4:0] raw);
        return (raw == 5'd0) ? 6'd32 : {1'b0, raw};
    endfunction

    function automatic logic [5:0] bf_clz(input logic [BF_FLD_W-1:0] v);
        logic [5:0] n;
        logic       seen;
        n    = 6'd0;
        seen = 1'b0;
        for (int i = BF_FLD_W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (v[i]) seen = 1'b1;
                else      n    = n + 6'd1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/bfu_locate.sv
module bfu_locate
    import bfu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [4:0]        len_raw,
    output logic [ADDR_W-1:0] acc_addr,
    output bf_loc_t           loc
);

    logic signed [OFS_W-1:0] byte_step;
    logic [2:0]              bit_in;
    logic [ADDR_W-1:0]       byte_addr;
    logic [5:0]              len_e;
    logic [5:0]              bit6;
    logic [2:0]              span;

    // floor division by 8 falls out of an arithmetic shift
    assign byte_step = $signed(ofs) >>> 3;
    assign bit_in    = ofs[2:0];
    assign bit6      = {3'b000, bit_in};
    assign byte_addr = base + ADDR_W'(byte_step);
    assign len_e     = bf_eff_len(len_raw);
    assign span      = 3'((bit6 + len_e - 6'd1) >> 3);

    always_comb begin
        acc_addr = byte_addr;
        loc.len  = len_e;
        loc.wpos = bit6;
        loc.size = SZ_BYTE;
        case (span)
            3'd0: begin
                loc.wpos = bit6 + 6'd56;
            end
            3'd1: begin
                loc.wpos = bit6 + 6'd48;
                loc.size = SZ_WORD;
            end
            3'd2, 3'd3: begin
                loc.size = SZ_LONG;
                loc.wpos = bit6 + 6'd32;
                if (span == 3'd2 && byte_addr[0]) begin
                    acc_addr = byte_addr - ADDR_W'(1);
                    loc.wpos = bit6 + 6'd40;
                end
            end
            default: begin
                loc.size = SZ_QUAD;
                loc.wpos = bit6 + {1'b0, byte_addr[1:0], 3'b000};
                acc_addr = {byte_addr[ADDR_W-1:2], 2'b00};
            end
        endcase
    end

endmodule

// File: rtl/bfu_apply.sv
module bfu_apply
    import bfu_pkg::*;
#(
    parameter int OFS_W = 32
) (
    input  bf_op_e                op,
    input  logic [BF_WIN_W-1:0]   win,
    input  bf_loc_t               loc,
    input  logic [BF_FLD_W-1:0]   ins_val,
    input  logic [OFS_W-1:0]      ofs,
    output logic [BF_FLD_W-1:0]   result,
    output logic [BF_FLD_W-1:0]   flag,
    output logic [BF_WIN_W-1:0]   st_win,
    output logic                  st_en
);

    logic [BF_FLD_W-1:0] len_mask, fld_lj, fld_z, fld_s, ins_lj, ofs32, probe;
    logic [BF_WIN_W-1:0] fmask, ins_win;
    logic [5:0]          rsh;

    assign len_mask = ~(32'hFFFF_FFFF >> loc.len);
    assign fld_lj   = 32'((win << loc.wpos) >> BF_FLD_W) & len_mask;
    assign rsh      = 6'd32 - loc.len;
    assign fld_z    = fld_lj >> rsh;
    assign fld_s    = 32'($signed(fld_lj) >>> rsh);
    assign fmask    = {len_mask, 32'h0} >> loc.wpos;
    assign ins_lj   = ins_val << rsh;
    assign ins_win  = {ins_lj, 32'h0} >> loc.wpos;
    assign ofs32    = 32'($signed(ofs));
    // sentinel one just past the field makes an all-zero field count as its length
    assign probe    = fld_lj | (32'h8000_0000 >> loc.len);

    always_comb begin
        result = '0;
        flag   = fld_lj;
        st_win = win;
        st_en  = 1'b0;
        case (op)
            BF_EXTU: result = fld_z;
            BF_EXTS: result = fld_s;
            BF_INS: begin
                result = ins_lj >> rsh;
                flag   = ins_lj;
                st_win = (win & ~fmask) | ins_win;
                st_en  = 1'b1;
            end
            BF_CHG: begin
                result = fld_z;
                st_win = win ^ fmask;
                st_en  = 1'b1;
            end
            BF_CLR: begin
                result = fld_z;
                st_win = win & ~fmask;
                st_en  = 1'b1;
            end
            BF_SET: begin
                result = fld_z;
                st_win = win | fmask;
                st_en  = 1'b1;
            end
            BF_FFO:  result = ofs32 + {26'b0, bf_clz(probe)};
            default: flag   = '0;
        endcase
    end

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
    import bfu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [ADDR_W-1:0] in_base,
    input  logic [OFS_W-1:0]  in_ofs,
    input  logic [4:0]        in_len,
    input  logic [31:0]       in_ins,
    input  logic [63:0]       win_in,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [1:0]        ld_size,
    output logic              out_valid,
    output logic [31:0]       out_result,
    output logic [31:0]       out_flag,
    output logic              st_en,
    output logic [63:0]       st_win,
    output logic [ADDR_W-1:0] st_addr,
    output logic [1:0]        st_size
);

    bf_loc_t             loc;
    logic [BF_FLD_W-1:0] a_result, a_flag;
    logic [BF_WIN_W-1:0] a_win;
    logic                a_st;

    bfu_locate #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_locate (
        .base     (in_base),
        .ofs      (in_ofs),
        .len_raw  (in_len),
        .acc_addr (ld_addr),
        .loc      (loc)
    );

    bfu_apply #(.OFS_W(OFS_W)) u_apply (
        .op      (bf_op_e'(in_op)),
        .win     (win_in),
        .loc     (loc),
        .ins_val (in_ins),
        .ofs     (in_ofs),
        .result  (a_result),
        .flag    (a_flag),
        .st_win  (a_win),
        .st_en   (a_st)
    );

    assign ld_size = loc.size;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            st_en      <= 1'b0;
            out_result <= '0;
            out_flag   <= '0;
            st_win     <= '0;
            st_addr    <= '0;
            st_size    <= '0;
        end else begin
            out_valid <= in_valid;
            st_en     <= in_valid & a_st;
            if (in_valid) begin
                out_result <= a_result;
                out_flag   <= a_flag;
                st_win     <= a_win;
                st_addr    <= ld_addr;
                st_size    <= ld_size;
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);  // R10
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);  // R10
    AST_STORE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        st_en |-> out_valid);  // R10
    AST_LONG_EVEN_ADDR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ld_size == 2'd2 && ((in_ofs[2:0] + {1'b0, in_len} - 6'd1) >> 3) == 6'd2
         && in_len != 5'd0) |-> !ld_addr[0]);  // R4
    AST_QUAD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ld_size == 2'd3) |-> (ld_addr[1:0] == 2'b00));  // R5
    AST_CLR_NO_NEW_ONES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd4) |=> ((st_win & ~$past(win_in)) == 64'h0));  // R7
    AST_SET_KEEPS_ONES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd5) |=> (($past(win_in) & ~st_win) == 64'h0));  // R7

endmodule

// File: tb/sim_bitfield_unit.sv
module sim_bitfield_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 16;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] base;
        logic [31:0] ofs;
        logic [4:0]  len;
        logic [31:0] ins;
        logic [31:0] eaddr;
        logic [1:0]  esz;
    } vec_t;

    // op, base, ofs, len, insert value, expected load address, expected size
    localparam vec_t VECS [0:NV-1] = '{
        '{3'd0, 32'h1000, 32'd3,        5'd4,  32'h0,        32'h1000, 2'd0},
        '{3'd1, 32'h1000, 32'd13,       5'd7,  32'h0,        32'h1001, 2'd1},
        '{3'd1, 32'h1000, 32'hFFFFFFFD, 5'd5,  32'h0,        32'h0FFF, 2'd1},
        '{3'd2, 32'h2000, 32'd20,       5'd12, 32'h0000FABC, 32'h2002, 2'd1},
        '{3'd3, 32'h2001, 32'd6,        5'd14, 32'h0,        32'h2000, 2'd2},
        '{3'd4, 32'h2000, 32'd6,        5'd14, 32'h0,        32'h2000, 2'd2},
        '{3'd5, 32'h3000, 32'd0,        5'd0,  32'h0,        32'h3000, 2'd2},
        '{3'd5, 32'h3001, 32'd2,        5'd0,  32'h0,        32'h3000, 2'd3},
        '{3'd6, 32'h3003, 32'd7,        5'd30, 32'h0,        32'h3000, 2'd3},
        '{3'd2, 32'h3002, 32'hFFFFFFFF, 5'd0,  32'hDEADBEEF, 32'h3000, 2'd3},
        '{3'd0, 32'h4000, 32'hFFFFFFEF, 5'd9,  32'h0,        32'h3FFD, 2'd1},
        '{3'd3, 32'h4000, 32'hFFFFFFEC, 5'd16, 32'h0,        32'h3FFC, 2'd2},
        '{3'd6, 32'h5000, 32'd5,        5'd20, 32'h0,        32'h5000, 2'd2},
        '{3'd7, 32'h1000, 32'd0,        5'd8,  32'h0,        32'h1000, 2'd0},
        '{3'd4, 32'h6000, 32'd63,       5'd1,  32'h0,        32'h6007, 2'd0},
        '{3'd1, 32'h6004, 32'd0,        5'd0,  32'h0,        32'h6004, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  in_op;
    logic [31:0] in_base, in_ofs, in_ins;
    logic [4:0]  in_len;
    logic [63:0] win_in;
    logic [31:0] ld_addr, st_addr, out_result, out_flag;
    logic [1:0]  ld_size, st_size;
    logic        out_valid, st_en;
    logic [63:0] st_win;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bitfield_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_base(in_base), .in_ofs(in_ofs), .in_len(in_len), .in_ins(in_ins),
        .win_in(win_in), .ld_addr(ld_addr), .ld_size(ld_size),
        .out_valid(out_valid), .out_result(out_result), .out_flag(out_flag),
        .st_en(st_en), .st_win(st_win), .st_addr(st_addr), .st_size(st_size)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        if (a >= 32'h5000 && a < 32'h5010) return 8'h00;
        return (a[7:0] * 8'd37) + (a[15:8] * 8'd101) + 8'd11;
    endfunction

    function automatic logic mem_bit(input longint ab);
        logic [7:0] b;
        b = mem_byte(32'(ab >>> 3));
        return b[7 - int'(ab & 64'd7)];
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0, 3'd1: return "R6";
            3'd2:       return "R8";
            3'd6:       return "R9";
            3'd7:       return "R10";
            default:    return "R7";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int          len_e, n, ffo_i;
        longint      start, wstart, ab;
        logic [63:0] w, exp_w;
        logic [31:0] fld, exp_res, exp_flag, lowm;
        bit          fit, exp_st;
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = v.op;
        in_base  = v.base;
        in_ofs   = v.ofs;
        in_len   = v.len;
        in_ins   = v.ins;
        #1;
        len_e  = (v.len == 5'd0) ? 32 : int'(v.len);  // R1
        start  = longint'(v.base) * 8 + longint'($signed(v.ofs));
        n      = 1 << ld_size;
        wstart = longint'(ld_addr) * 8;
        fit    = (start >= wstart) && (start + len_e <= wstart + n * 8);
        chk((ld_addr == v.eaddr) && (ld_size == v.esz) && fit,
            "R2 R3 R4 R5", "load address/size", {ld_addr, 30'b0, ld_size},
            {v.eaddr, 30'b0, v.esz});
        w = '0;
        for (int k = 0; k < n; k++) w = (w << 8) | 64'(mem_byte(ld_addr + 32'(k)));
        win_in = w;
        fld   = '0;
        ffo_i = len_e;
        for (int i = 0; i < len_e; i++) begin
            fld = (fld << 1) | 32'(mem_bit(start + i));
            if (mem_bit(start + i) && ffo_i == len_e) ffo_i = i;
        end
        lowm  = (len_e == 32) ? 32'hFFFF_FFFF : ((32'd1 << len_e) - 32'd1);
        exp_w = w;
        for (int j = 0; j < n * 8; j++) begin
            ab = wstart + j;
            if (ab >= start && ab < start + len_e) begin
                case (v.op)
                    3'd2: exp_w[n*8-1-j] = v.ins[len_e - 1 - int'(ab - start)];
                    3'd3: exp_w[n*8-1-j] = ~exp_w[n*8-1-j];
                    3'd4: exp_w[n*8-1-j] = 1'b0;
                    3'd5: exp_w[n*8-1-j] = 1'b1;
                    default: ;
                endcase
            end
        end
        exp_st   = (v.op >= 3'd2) && (v.op <= 3'd5);
        exp_flag = fld << (32 - len_e);
        case (v.op)
            3'd1:    exp_res = fld[len_e-1] ? (fld | ~lowm) : fld;
            3'd2: begin
                exp_res  = v.ins & lowm;
                exp_flag = v.ins << (32 - len_e);
            end
            3'd6:    exp_res = v.ofs + 32'(ffo_i);
            3'd7: begin
                exp_res  = '0;
                exp_flag = '0;
            end
            default: exp_res = fld;
        endcase
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R10", "out_valid after request", 64'(out_valid), 64'd1);
        chk((st_addr == v.eaddr) && (st_size == v.esz), "R12", "store address/size",
            {st_addr, 30'b0, st_size}, {v.eaddr, 30'b0, v.esz});
        chk(out_result == exp_res, req_of(v.op), "result", 64'(out_result), 64'(exp_res));
        chk(out_flag == exp_flag, req_of(v.op), "flag value", 64'(out_flag), 64'(exp_flag));
        chk(st_en == exp_st, req_of(v.op), "store enable", 64'(st_en), 64'(exp_st));
        if (exp_st)
            chk(st_win == exp_w, req_of(v.op), "store window", st_win, exp_w);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        in_op    = '0;
        in_base  = '0;
        in_ofs   = '0;
        in_len   = '0;
        in_ins   = '0;
        win_in   = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!out_valid && !st_en && out_result == 0 && out_flag == 0, "R11", "reset state",
            {out_valid, st_en, out_result[29:0], out_flag}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        // R10: idle cycle gives no valid
        chk(out_valid == 1'b0, "R10", "idle out_valid", 64'(out_valid), 64'd0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R11: reset overrides a request in the same cycle
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = 3'd5;
        in_base  = 32'h3000;
        in_ofs   = 32'd0;
        in_len   = 5'd8;
        win_in   = 64'hFF;
        rst      = 1'b1;
        @(negedge clk);
        chk(!out_valid && !st_en && out_result == 0, "R11", "reset beats request",
            {out_valid, st_en, out_result[29:0], 32'b0}, 64'd0);
        in_valid = 1'b0;
        rst      = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "no valid after dropped request", 64'(out_valid), 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule